// File: doc/BRIEF.md
# Cascaded Interrupt Vector Arbiter

This block sits between two eight-level interrupt controllers arranged as a primary and a secondary and the processor's interrupt pin. Each controller presents its pending requests (already filtered by its mask), its in-service bits, the level that currently has the lowest priority and its vector base as a stub interface. The arbiter resolves the highest eligible level of each controller with a rotating priority scan. It signals the secondary's request to the primary's cascade level as a one-cycle pulse. It also raises the processor interrupt line.

The vector for the processor is presented combinationally at all times. When the processor acknowledges, it returns the vector as a single-cycle strobe. The arbiter then routes the acceptance to the controller, or to both controllers, that owns the vector, and clears the corresponding raised flags. A new request can then be raised.

Top module: `cascade_vector_arb`

## Requirements
- R1: A level is eligible when its request bit is set and no in-service bit is set at the same level or at any level of higher priority. Priority starts at the level after `*_lowprio` and wraps modulo 8, so `*_lowprio` itself has the lowest priority.
- R2: When `pri_sfn` is high, the primary's in-service bit at level 2 is ignored in the primary's scan. The secondary has no such mode.
- R3: `casc_pulse` is high for one cycle when the secondary has an eligible level, is not already raised and is not being acknowledged. It stays low from then on until the secondary is acknowledged.
- R4: `cpu_intr` rises in the cycle after the primary has an eligible level while not raised. It stays high until a primary acknowledge.
- R5: When the primary's highest eligible level is not 2, `vector` is `{pri_base, level}`.
- R6: When the primary's highest eligible level is 2, `vector` is `{sec_base, level}`, using the secondary's highest eligible level.
- R7: When the chosen controller has no eligible level, `vector` carries level 7 of that controller (`{pri_base,7}` or `{sec_base,7}`).
- R8: An acknowledge whose `ack_vector[7:3]` equals `sec_base` pulses `sec_ack_valid` with level `ack_vector[2:0]`. It also pulses `pri_ack_valid` with level 2.
- R9: Any other acknowledge pulses only `pri_ack_valid`, with level `ack_vector[2:0]`. With `ack_valid` low, neither acknowledge output is high.
- R10: An acknowledge clears the raised flag of each controller it reaches. `cpu_intr` is low in the following cycle, and a still-eligible controller is raised again one cycle later.
- R11: Synchronous active-low reset clears both raised flags, so `cpu_intr` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_req | input | 8 | Primary unmasked pending requests |
| pri_isr | input | 8 | Primary in-service bits |
| pri_lowprio | input | 3 | Primary lowest-priority level |
| pri_base | input | 5 | Primary vector base (vector bits 7:3) |
| pri_sfn | input | 1 | Primary special fully nested mode |
| sec_req | input | 8 | Secondary unmasked pending requests |
| sec_isr | input | 8 | Secondary in-service bits |
| sec_lowprio | input | 3 | Secondary lowest-priority level |
| sec_base | input | 5 | Secondary vector base |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_vector | input | 8 | Vector being acknowledged |
| vector | output | 8 | Vector for the processor |
| cpu_intr | output | 1 | Interrupt line to the processor |
| casc_pulse | output | 1 | Cascade pulse to primary level 2 |
| pri_ack_valid | output | 1 | Acceptance strobe to primary |
| pri_ack_level | output | 3 | Level accepted by primary |
| sec_ack_valid | output | 1 | Acceptance strobe to secondary |
| sec_ack_level | output | 3 | Level accepted by secondary |

## Verification
The hardest situation to reach is an acknowledge that lands in the same cycle as a fresh eligible request. This arrangement must suppress the raise for one cycle and then re-raise it, and it has to coincide with a base match that decides the routing. Random stimulus draws acknowledge vectors half the time from the secondary base, so that both routes and these coincidences recur. Directed cases cover rotation wrap, in-service blocking, the special nested mode on level 2, and both spurious forms.

// File: rtl/cascade_arb_pkg.sv
// Shared constants and types for the cascaded vector arbiter.
// Assumes eight levels per controller and an eight-bit vector.
package cascade_arb_pkg;
    localparam int LVL_N  = 8;
    localparam int LVL_W  = $clog2(LVL_N);
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - LVL_W;

    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] lvl;
    } lvl_ack_t;

    typedef struct packed {
        logic             found;
        logic [LVL_W-1:0] lvl;
    } scan_res_t;
endpackage

// File: rtl/cascade_prio_scan.sv
// Rotating priority scan for one controller.
// Starts one level above lowprio and wraps around. It stops at the first
// in-service bit, or reports the first pending request before that point.
// Assumes req is already masked.
module cascade_prio_scan
    import cascade_arb_pkg::*;
(
    input  logic [LVL_N-1:0] req,
    input  logic [LVL_N-1:0] serv,
    input  logic [LVL_W-1:0] lowprio,
    output scan_res_t        res
);
    logic [LVL_W-1:0] idx;
    logic             stop;

    // Walk the levels from highest to lowest priority.
    always_comb begin
        res  = '0;
        stop = 1'b0;
        idx  = '0;
        for (int k = 0; k < LVL_N; k++) begin
            idx = lowprio + LVL_W'(k + 1);
            if (!stop) begin
                if (serv[idx]) begin
                    stop = 1'b1;
                end else if (req[idx]) begin
                    res.found = 1'b1;
                    res.lvl   = idx;
                    stop      = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cascade_ack_route.sv
// Routes a processor acknowledge to the owning controller(s).
// A vector matching the secondary base reaches the secondary and also
// accepts the cascade level of the primary.
module cascade_ack_route
    import cascade_arb_pkg::*;
#(
    parameter int CASC_LVL = 2
) (
    input  logic              ack_valid,
    input  logic [VEC_W-1:0]  ack_vector,
    input  logic [BASE_W-1:0] sec_base,
    output lvl_ack_t          pri_ack,
    output lvl_ack_t          sec_ack
);
    logic from_sec;

    // Decode the owner from the vector's upper bits.
    always_comb begin
        from_sec    = (ack_vector[VEC_W-1:LVL_W] == sec_base);
        sec_ack.vld = ack_valid && from_sec;
        sec_ack.lvl = ack_vector[LVL_W-1:0];
        pri_ack.vld = ack_valid;
        pri_ack.lvl = from_sec ? LVL_W'(CASC_LVL) : ack_vector[LVL_W-1:0];
    end
endmodule

// File: rtl/cascade_vector_arb.sv
// Top of the cascaded interrupt vector arbiter.
// Resolves both controllers and keeps one raised flag per controller.
// Pulses the cascade level, drives the processor line, selects the vector
// and routes acknowledges. Assumes the controllers register their own
// request, in-service and rotation state from the acknowledge outputs.
module cascade_vector_arb
    import cascade_arb_pkg::*;
#(
    parameter int CASC_LVL = 2,
    parameter int SPUR_LVL = LVL_N - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_N-1:0]  pri_req,
    input  logic [LVL_N-1:0]  pri_isr,
    input  logic [LVL_W-1:0]  pri_lowprio,
    input  logic [BASE_W-1:0] pri_base,
    input  logic              pri_sfn,
    input  logic [LVL_N-1:0]  sec_req,
    input  logic [LVL_N-1:0]  sec_isr,
    input  logic [LVL_W-1:0]  sec_lowprio,
    input  logic [BASE_W-1:0] sec_base,
    input  logic              ack_valid,
    input  logic [VEC_W-1:0]  ack_vector,
    output logic [VEC_W-1:0]  vector,
    output logic              cpu_intr,
    output logic              casc_pulse,
    output logic              pri_ack_valid,
    output logic [LVL_W-1:0]  pri_ack_level,
    output logic              sec_ack_valid,
    output logic [LVL_W-1:0]  sec_ack_level
);
    localparam logic [LVL_N-1:0] CASC_BIT = LVL_N'(1) << CASC_LVL;

    logic [LVL_N-1:0] pri_serv;
    scan_res_t        pri_res, sec_res;
    lvl_ack_t         pri_ack, sec_ack;
    logic             pri_raised, sec_raised;
    logic             pri_raise, sec_raise;

    // Special nested mode frees the cascade level on the primary only.
    always_comb pri_serv = pri_isr & ~(pri_sfn ? CASC_BIT : '0);

    cascade_prio_scan u_pri_scan (
        .req(pri_req), .serv(pri_serv), .lowprio(pri_lowprio), .res(pri_res)
    );

    cascade_prio_scan u_sec_scan (
        .req(sec_req), .serv(sec_isr), .lowprio(sec_lowprio), .res(sec_res)
    );

    cascade_ack_route #(.CASC_LVL(CASC_LVL)) u_route (
        .ack_valid(ack_valid), .ack_vector(ack_vector), .sec_base(sec_base),
        .pri_ack(pri_ack), .sec_ack(sec_ack)
    );

    // Raise decisions: eligible, not yet raised, not being accepted now.
    always_comb begin
        sec_raise = sec_res.found && !sec_raised && !sec_ack.vld;
        pri_raise = pri_res.found && !pri_raised && !pri_ack.vld;
    end

    // Raised flags: set on raise, cleared by acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_raised <= 1'b0;
            sec_raised <= 1'b0;
        end else begin
            pri_raised <= pri_ack.vld ? 1'b0 : (pri_raised || pri_raise);
            sec_raised <= sec_ack.vld ? 1'b0 : (sec_raised || sec_raise);
        end
    end

    // Vector select: cascade level defers to the secondary, else spurious.
    always_comb begin
        if (pri_res.found && pri_res.lvl == LVL_W'(CASC_LVL)) begin
            vector = sec_res.found ? {sec_base, sec_res.lvl}
                                   : {sec_base, LVL_W'(SPUR_LVL)};
        end else if (pri_res.found) begin
            vector = {pri_base, pri_res.lvl};
        end else begin
            vector = {pri_base, LVL_W'(SPUR_LVL)};
        end
    end

    // Output wiring.
    always_comb begin
        cpu_intr      = pri_raised;
        casc_pulse    = sec_raise;
        pri_ack_valid = pri_ack.vld;
        pri_ack_level = pri_ack.lvl;
        sec_ack_valid = sec_ack.vld;
        sec_ack_level = sec_ack.lvl;
    end
endmodule

// File: rtl/cascade_vector_arb_chk.sv
// Port-level checker for the cascaded vector arbiter, bound to the top.
module cascade_vector_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] pri_base,
    input logic [4:0] sec_base,
    input logic       ack_valid,
    input logic [7:0] ack_vector,
    input logic [7:0] vector,
    input logic       cpu_intr,
    input logic       casc_pulse,
    input logic       pri_ack_valid,
    input logic [2:0] pri_ack_level,
    input logic       sec_ack_valid,
    input logic [2:0] sec_ack_level
);
    assert_pulse_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        casc_pulse && !sec_ack_valid |=> !casc_pulse);

    assert_intr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_intr && !pri_ack_valid |=> cpu_intr);

    assert_vec_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vector[7:3] == pri_base || vector[7:3] == sec_base);

    assert_sec_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_ack_valid |-> pri_ack_valid && pri_ack_level == 3'd2
                          && sec_ack_level == ack_vector[2:0]);

    assert_no_spurious_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |-> !pri_ack_valid && !sec_ack_valid);

    assert_ack_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pri_ack_valid |=> !cpu_intr);

    assert_reset_low_R11: assert property (@(posedge clk)
        !rst_n |=> !cpu_intr);
endmodule

bind cascade_vector_arb cascade_vector_arb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pri_base(pri_base), .sec_base(sec_base),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .vector(vector),
    .cpu_intr(cpu_intr), .casc_pulse(casc_pulse),
    .pri_ack_valid(pri_ack_valid), .pri_ack_level(pri_ack_level),
    .sec_ack_valid(sec_ack_valid), .sec_ack_level(sec_ack_level)
);

// File: tb/cascade_vector_arb_bench.sv
`timescale 1ns/1ps
module cascade_vector_arb_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic [7:0] pri_req, pri_isr, sec_req, sec_isr, ack_vector;
    logic [2:0] pri_lowprio, sec_lowprio;
    logic [4:0] pri_base, sec_base;
    logic       pri_sfn, ack_valid;
    logic [7:0] vector;
    logic       cpu_intr, casc_pulse, pri_ack_valid, sec_ack_valid;
    logic [2:0] pri_ack_level, sec_ack_level;

    cascade_vector_arb u_cascade_vector_arb (.*);

    int checks = 0;
    int errors = 0;
    bit m_raised = 0;
    bit s_raised = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench model of the priority scan: {found, level}.
    function automatic logic [3:0] scan(logic [7:0] r, logic [7:0] s, logic [2:0] lp);
        logic [2:0] p = lp;
        for (int n = 0; n < 8; n++) begin
            p = p + 3'd1;
            if (s[p]) return 4'd0;
            if (r[p]) return {1'b1, p};
        end
        return 4'd0;
    endfunction

    function automatic logic [3:0] pri_scan();
        return scan(pri_req, pri_isr & ~(pri_sfn ? 8'h04 : 8'h00), pri_lowprio);
    endfunction

    // Check all outputs against the model, then advance the model a cycle.
    task automatic step();
        logic [3:0] mf, sf;
        logic [7:0] ev;
        string vt;
        bit acc_s, m_up, s_up;
        #1;
        mf = pri_scan();
        sf = scan(sec_req, sec_isr, sec_lowprio);
        if (mf[3] && mf[2:0] == 3'd2) begin
            ev = sf[3] ? {sec_base, sf[2:0]} : {sec_base, 3'd7};
            vt = sf[3] ? "R6 vector" : "R7 vector";
        end else if (mf[3]) begin
            ev = {pri_base, mf[2:0]}; vt = "R5 vector";
        end else begin
            ev = {pri_base, 3'd7}; vt = "R7 vector";
        end
        chk(vt, vector, ev);
        acc_s = ack_valid && (ack_vector[7:3] == sec_base);
        chk("R8 sec ack", {sec_ack_valid, acc_s ? sec_ack_level : 3'd0},
            {acc_s, acc_s ? ack_vector[2:0] : 3'd0});
        chk("R9 pri ack", {pri_ack_valid, ack_valid ? pri_ack_level : 3'd0},
            {ack_valid, ack_valid ? (acc_s ? 3'd2 : ack_vector[2:0]) : 3'd0});
        chk("R3 cascade pulse", casc_pulse, sf[3] && !s_raised && !acc_s);
        chk("R4 R10 cpu_intr", cpu_intr, m_raised);
        m_up = ack_valid ? 1'b0 : (m_raised || mf[3]);
        s_up = acc_s ? 1'b0 : (s_raised || sf[3]);
        @(posedge clk);
        m_raised = m_up;
        s_raised = s_up;
        @(negedge clk);
    endtask

    task automatic idle();
        pri_req = 0; pri_isr = 0; sec_req = 0; sec_isr = 0;
        pri_lowprio = 3'd7; sec_lowprio = 3'd7; pri_sfn = 0;
        ack_valid = 0; ack_vector = 0;
    endtask

    bit done = 0;
    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        idle();
        pri_base = 5'h01; sec_base = 5'h0E;
        rst_n = 0;
        pri_req = 8'hFF; sec_req = 8'hFF;
        repeat (3) @(negedge clk);
        #1 chk("R11 reset cpu_intr", cpu_intr, 0);
        idle();
        @(posedge clk); rst_n = 1; @(negedge clk);
        chk("R11 after reset", cpu_intr, 0);
        step();                                  // spurious primary R7

        pri_req = 8'h20; step();                 // R5, raise
        #1 chk("R4 raised", cpu_intr, 1);
        ack_valid = 1; ack_vector = {pri_base, 3'd5}; step();
        ack_valid = 0;
        #1 chk("R10 dropped", cpu_intr, 0);
        step(); step();
        #1 chk("R10 re-raised", cpu_intr, 1);

        pri_req = 8'h42; pri_lowprio = 3'd3; #1;
        chk("R1 rotation wrap", pri_scan(), {1'b1, 3'd6});
        pri_lowprio = 3'd6; #1;
        chk("R1 rotation low", pri_scan(), {1'b1, 3'd1});
        pri_req = 8'h20; pri_isr = 8'h08; pri_lowprio = 3'd7; step();
        chk("R1 isr blocks", vector, {pri_base, 3'd7});

        pri_isr = 0; pri_req = 8'h04; sec_req = 8'h10; step();
        chk("R6 cascade vector", vector, {sec_base, 3'd4});
        sec_req = 0; step();
        chk("R7 sec spurious", vector, {sec_base, 3'd7});

        pri_isr = 8'h04; sec_req = 8'h08; pri_sfn = 0; step();
        chk("R2 blocked without sfn", vector, {pri_base, 3'd7});
        pri_sfn = 1; step();
        chk("R2 sfn frees level 2", vector, {sec_base, 3'd3});
        ack_valid = 1; ack_vector = {sec_base, 3'd3}; step();
        ack_valid = 0; idle();
        step(); step();

        for (int i = 0; i < 3000; i++) begin
            pri_req     = $urandom & $urandom;
            sec_req     = $urandom & $urandom;
            pri_isr     = $urandom & $urandom & $urandom;
            sec_isr     = $urandom & $urandom & $urandom;
            pri_lowprio = $urandom;
            sec_lowprio = $urandom;
            pri_sfn     = $urandom;
            if (($urandom % 64) == 0) begin
                pri_base = $urandom; sec_base = $urandom;
            end
            ack_valid  = ($urandom % 4) == 0;
            ack_vector = $urandom;
            if ($urandom % 2) ack_vector[7:3] = sec_base;
            step();
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule